// File: doc/BRIEF.md
# Dual-Line Vectored Interrupt Controller

The block gathers level-sensitive requests from up to 32 on-chip sources and folds them onto two processor request lines: a fast line for urgent work and a normal line for everything else. Each source has an enable bit, a line-select bit, a 4-bit priority and a software request bit that is ORed with its hardware input. The combined request of each source, before any enable or priority filtering, can be read at any time.

For each line the block keeps a registered vector naming the source that should be served next, together with that source's priority. Nested service uses a priority threshold per line. Software acknowledges a request by reading that line's vector register. The read saves the current threshold on a small per-line stack and raises the threshold to the winner's priority, so only strictly more urgent sources can interrupt the handler. Writing the line's end-of-service register restores the saved threshold. All configuration and acknowledgement goes through a single-cycle register port with a 6-bit word address.

Top module: `dli_top`

## Requirements
- R1: After reset all enable, line-select and software request bits are 0, both thresholds are 0, both nesting stacks are empty, both request lines are low and both vector registers read 0.
- R2: The raw status register (address 0x04) reads, for each source, its hardware input ORed with its software request bit, independent of enable, priority and line-select.
- R3: Writing a 1 to a bit of the software-set register (0x02) sets that source's software request bit, and writing a 1 to a bit of the software-clear register (0x03) clears it. Written 0 bits change nothing. Reading either address returns the software request bits. A hardware level request stays visible in raw status after a clear.
- R4: Requests are level-sensitive. When a source's input falls and it has no software request, it no longer takes part in arbitration from the next clock edge.
- R5: A source takes part only on the line its line-select bit names (register 0x01, 1 = fast line, 0 = normal line). A request line is asserted, one clock edge after its inputs, exactly when some such source is pending, enabled (register 0x00) and has a priority above that line's threshold.
- R6: A source whose priority is 0 never asserts either line.
- R7: Each vector register holds the index of the eligible source with the highest priority, with ties going to the lowest index, and is registered one edge after its inputs. The vector read word is bit 31 = valid, bits 11:8 = priority, bits 4:0 = index. The fast vector is at 0x08 and the normal vector at 0x09. Each source's priority is written at 0x20 plus its index.
- R8: Reading a line's vector while it is valid pushes that line's threshold and sets the threshold to the winner's priority. Sources at or below that priority are then held off, and a strictly higher one asserts the line again (nesting).
- R9: Writing the fast (0x0A) or normal (0x0B) end-of-service register pops the saved threshold back. With an empty stack the write is ignored and the threshold stays 0.
- R10: The stack of each line is 4 deep. A vector read with a full stack, or with no valid winner, leaves the threshold unchanged.
- R11: The current thresholds read at 0x0C (fast) and 0x0D (normal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NSRC (32) | Level request from each source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (vector reads acknowledge) |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the address |
| irq_fast_o | output | 1 | Fast, high-priority request line |
| irq_norm_o | output | 1 | Normal-priority request line |
| vec_fast_o | output | IDX_W (5) | Current fast-line winner index |
| vec_norm_o | output | IDX_W (5) | Current normal-line winner index |

## Verification
The bench goes after equal-priority ties, where a design that let the last index win would name source 7 instead of source 3. It drives a disabled source of top priority, which a design that filtered only on priority would serve. It fills the nesting stack, where an unguarded push would overwrite the oldest threshold or take the threshold past the fifth read, and it writes end-of-service on an empty stack, which a design without that guard would wrap into a garbage threshold. It also checks that a software clear leaves a hardware level visible, and that a dropped input hands the vector to the next source one edge later rather than holding a stale winner.

// File: rtl/dli_pkg.sv
package dli_pkg;
    localparam int ADDR_W = 6;

    typedef enum logic [1:0] {
        NEST_EMPTY,
        NEST_MID,
        NEST_FULL
    } nest_state_e;

    localparam logic [ADDR_W-1:0] A_ENABLE = 6'h00;
    localparam logic [ADDR_W-1:0] A_ROUTE  = 6'h01;
    localparam logic [ADDR_W-1:0] A_SWSET  = 6'h02;
    localparam logic [ADDR_W-1:0] A_SWCLR  = 6'h03;
    localparam logic [ADDR_W-1:0] A_RAW    = 6'h04;
    localparam logic [ADDR_W-1:0] A_FVEC   = 6'h08;
    localparam logic [ADDR_W-1:0] A_NVEC   = 6'h09;
    localparam logic [ADDR_W-1:0] A_FEOI   = 6'h0A;
    localparam logic [ADDR_W-1:0] A_NEOI   = 6'h0B;
    localparam logic [ADDR_W-1:0] A_FTHR   = 6'h0C;
    localparam logic [ADDR_W-1:0] A_NTHR   = 6'h0D;
    localparam logic [ADDR_W-1:0] A_PRIO   = 6'h20;
endpackage

// File: rtl/dli_regs.sv
module dli_regs
    import dli_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int PW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   route_o,
    output logic [NSRC-1:0]   sw_o,
    output logic [NSRC*PW-1:0] prio_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o    <= '0;
            route_o <= '0;
            sw_o    <= '0;
        end else if (wr_i) begin
            unique case (addr_i)
                A_ENABLE: en_o    <= wdata_i[NSRC-1:0];
                A_ROUTE:  route_o <= wdata_i[NSRC-1:0];
                A_SWSET:  sw_o    <= sw_o | wdata_i[NSRC-1:0];
                A_SWCLR:  sw_o    <= sw_o & ~wdata_i[NSRC-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_o <= '0;
        end else if (wr_i) begin
            for (int i = 0; i < NSRC; i++) begin
                if (addr_i == (A_PRIO | ADDR_W'(i)))
                    prio_o[i*PW +: PW] <= wdata_i[PW-1:0];
            end
        end
    end
endmodule

// File: rtl/dli_arb.sv
module dli_arb #(
    parameter int NSRC     = 32,
    parameter int PW       = 4,
    parameter bit LINE_SEL = 1'b0,
    localparam int IDX_W   = $clog2(NSRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    pend_i,
    input  logic [NSRC-1:0]    en_i,
    input  logic [NSRC-1:0]    route_i,
    input  logic [NSRC*PW-1:0] prio_i,
    input  logic [PW-1:0]      thr_i,
    output logic               vld_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [PW-1:0]      prio_o
);
    logic             best_v;
    logic [IDX_W-1:0] best_i;
    logic [PW-1:0]    best_p;

    always_comb begin
        best_v = 1'b0;
        best_i = '0;
        best_p = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && en_i[i] && (route_i[i] == LINE_SEL) &&
                (prio_i[i*PW +: PW] > thr_i) &&
                (!best_v || (prio_i[i*PW +: PW] > best_p))) begin
                best_v = 1'b1;
                best_i = IDX_W'(i);
                best_p = prio_i[i*PW +: PW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            idx_o  <= '0;
            prio_o <= '0;
        end else begin
            vld_o  <= best_v;
            idx_o  <= best_i;
            prio_o <= best_p;
        end
    end
endmodule

// File: rtl/dli_nest.sv
module dli_nest
    import dli_pkg::*;
#(
    parameter int PW    = 4,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_i,
    input  logic        pop_i,
    input  logic [PW-1:0] prio_i,
    output logic [PW-1:0] thr_o,
    output nest_state_e state_o
);
    nest_state_e     state_q, state_d;
    logic [CW-1:0]   depth_q;
    logic [PW-1:0]   stack_q [DEPTH];
    logic [PW-1:0]   thr_q;
    logic            do_push, do_pop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NEST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        do_push = 1'b0;
        do_pop  = 1'b0;
        unique case (state_q)
            NEST_EMPTY: begin
                if (push_i) begin
                    do_push = 1'b1;
                    state_d = NEST_MID;
                end
            end
            NEST_MID: begin
                if (push_i) begin
                    do_push = 1'b1;
                    if (depth_q == CW'(DEPTH - 1)) state_d = NEST_FULL;
                end else if (pop_i) begin
                    do_pop = 1'b1;
                    if (depth_q == CW'(1)) state_d = NEST_EMPTY;
                end
            end
            NEST_FULL: begin
                if (pop_i) begin
                    do_pop  = 1'b1;
                    state_d = NEST_MID;
                end
            end
            default: state_d = NEST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            thr_q   <= '0;
            for (int i = 0; i < DEPTH; i++) stack_q[i] <= '0;
        end else if (do_push) begin
            stack_q[depth_q[IW-1:0]] <= thr_q;
            thr_q   <= prio_i;
            depth_q <= depth_q + CW'(1);
        end else if (do_pop) begin
            thr_q   <= stack_q[IW'(depth_q - CW'(1))];
            depth_q <= depth_q - CW'(1);
        end
    end

    assign thr_o   = thr_q;
    assign state_o = state_q;
endmodule

// File: rtl/dli_top.sv
module dli_top
    import dli_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int PW    = 4,
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_i,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_fast_o,
    output logic              irq_norm_o,
    output logic [IDX_W-1:0]  vec_fast_o,
    output logic [IDX_W-1:0]  vec_norm_o
);
    logic [NSRC-1:0]    en, route, sw, pend;
    logic [NSRC*PW-1:0] prio;
    logic               vld_w   [2];
    logic [IDX_W-1:0]   idx_w   [2];
    logic [PW-1:0]      vprio_w [2];
    logic [PW-1:0]      thr_w   [2];
    nest_state_e        st_w    [2];

    dli_regs #(.NSRC(NSRC), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .en_o(en), .route_o(route), .sw_o(sw), .prio_o(prio)
    );

    assign pend = irq_i | sw;

    // line 0 = normal, line 1 = fast
    for (genvar l = 0; l < 2; l++) begin : g_line
        localparam logic [ADDR_W-1:0] VEC_A = (l == 1) ? A_FVEC : A_NVEC;
        localparam logic [ADDR_W-1:0] EOI_A = (l == 1) ? A_FEOI : A_NEOI;
        logic ack, eoi;
        assign ack = reg_rd && (reg_addr == VEC_A) && vld_w[l];
        assign eoi = reg_wr && (reg_addr == EOI_A);

        dli_arb #(.NSRC(NSRC), .PW(PW), .LINE_SEL(l == 1)) u_arb (
            .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .route_i(route),
            .prio_i(prio), .thr_i(thr_w[l]), .vld_o(vld_w[l]), .idx_o(idx_w[l]),
            .prio_o(vprio_w[l])
        );

        dli_nest #(.PW(PW), .DEPTH(DEPTH)) u_nest (
            .clk(clk), .rst_n(rst_n), .push_i(ack), .pop_i(eoi),
            .prio_i(vprio_w[l]), .thr_o(thr_w[l]), .state_o(st_w[l])
        );
    end

    assign irq_fast_o = vld_w[1];
    assign irq_norm_o = vld_w[0];
    assign vec_fast_o = idx_w[1];
    assign vec_norm_o = idx_w[0];

    function automatic logic [31:0] vec_word(input logic v, input logic [PW-1:0] p,
                                             input logic [IDX_W-1:0] ix);
        logic [31:0] w;
        w = '0;
        w[31] = v;
        w[8 +: PW] = p;
        w[IDX_W-1:0] = ix;
        return w;
    endfunction

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_ENABLE: reg_rdata = 32'(en);
            A_ROUTE:  reg_rdata = 32'(route);
            A_SWSET,
            A_SWCLR:  reg_rdata = 32'(sw);
            A_RAW:    reg_rdata = 32'(pend);
            A_FVEC:   reg_rdata = vec_word(vld_w[1], vprio_w[1], idx_w[1]);
            A_NVEC:   reg_rdata = vec_word(vld_w[0], vprio_w[0], idx_w[0]);
            A_FTHR:   reg_rdata = 32'(thr_w[1]);
            A_NTHR:   reg_rdata = 32'(thr_w[0]);
            default: begin
                for (int i = 0; i < NSRC; i++)
                    if (reg_addr == (A_PRIO | ADDR_W'(i))) reg_rdata = 32'(prio[i*PW +: PW]);
            end
        endcase
    end
endmodule

// File: rtl/dli_chk.sv
module dli_chk
    import dli_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int PW   = 4,
    localparam int IDX_W = $clog2(NSRC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [NSRC-1:0]   sw,
    input logic [NSRC-1:0]   route,
    input logic              irq_fast_o,
    input logic [IDX_W-1:0]  vec_fast_o,
    input logic [PW-1:0]     vprio_f,
    input logic [PW-1:0]     thr_f,
    input logic [PW-1:0]     thr_n,
    input nest_state_e       st_f,
    input nest_state_e       st_n
);
    AST_ACK_RAISES_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_FVEC && irq_fast_o && st_f != NEST_FULL) |=> (thr_f == $past(vprio_f))); // R8
    AST_FULL_HOLDS_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_FVEC && st_f == NEST_FULL) |=> $stable(thr_f)); // R10
    AST_EMPTY_FAST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_f == NEST_EMPTY) |-> (thr_f == '0)); // R9
    AST_EMPTY_NORM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_n == NEST_EMPTY) |-> (thr_n == '0)); // R9
    AST_EOI_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_FEOI && st_f == NEST_EMPTY) |=> (st_f == NEST_EMPTY)); // R9
    AST_SWSET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SWSET) |=> ((sw & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0]))); // R3
    AST_SWCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SWCLR) |=> ((sw & $past(reg_wdata[NSRC-1:0])) == '0)); // R3
    AST_FAST_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast_o |-> ((($past(route) >> vec_fast_o) & NSRC'(1)) == NSRC'(1))); // R5
    AST_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast_o |-> (vprio_f > $past(thr_f))); // R8
    AST_PRIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast_o |-> (vprio_f != '0)); // R6
endmodule

bind dli_top dli_chk #(.NSRC(NSRC), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sw(sw), .route(route), .irq_fast_o(irq_fast_o),
    .vec_fast_o(vec_fast_o), .vprio_f(vprio_w[1]), .thr_f(thr_w[1]), .thr_n(thr_w[0]),
    .st_f(st_w[1]), .st_n(st_w[0])
);

// File: tb/sim_dli_top.sv
module sim_dli_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_fast_o, irq_norm_o;
    logic [4:0]  vec_fast_o, vec_norm_o;

    int n_chk = 0, n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    dli_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_fast_o(irq_fast_o), .irq_norm_o(irq_norm_o),
        .vec_fast_o(vec_fast_o), .vec_norm_o(vec_norm_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_en = '0, m_route = '0, m_sw = '0;
    int          m_prio [32];
    int          m_thr  [2];
    int          stk0 [$];
    int          stk1 [$];
    bit          ev [2];
    int          ei [2];
    int          ep [2];

    function automatic void pick(input int l, output bit v, output int ix, output int p);
        v = 0; ix = 0; p = 0;
        for (int i = 0; i < 32; i++) begin
            if ((irq[i] || m_sw[i]) && m_en[i] && (int'(m_route[i]) == l) &&
                m_prio[i] > m_thr[l] && m_prio[i] > p) begin
                v = 1; ix = i; p = m_prio[i];
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_route = '0; m_sw = '0;
            for (int i = 0; i < 32; i++) m_prio[i] = 0;
            m_thr[0] = 0; m_thr[1] = 0; stk0.delete(); stk1.delete();
            ev[0] = 0; ev[1] = 0; ei[0] = 0; ei[1] = 0; ep[0] = 0; ep[1] = 0;
        end else begin
            bit nv [2];
            int ni [2];
            int np [2];
            pick(0, nv[0], ni[0], np[0]);
            pick(1, nv[1], ni[1], np[1]);
            if (reg_rd && reg_addr == 6'h09 && ev[0] && stk0.size() < 4) begin
                stk0.push_back(m_thr[0]); m_thr[0] = ep[0];
            end
            if (reg_rd && reg_addr == 6'h08 && ev[1] && stk1.size() < 4) begin
                stk1.push_back(m_thr[1]); m_thr[1] = ep[1];
            end
            if (reg_wr) begin
                case (reg_addr)
                    6'h00: m_en = reg_wdata;
                    6'h01: m_route = reg_wdata;
                    6'h02: m_sw = m_sw | reg_wdata;
                    6'h03: m_sw = m_sw & ~reg_wdata;
                    6'h0A: if (stk1.size() > 0) m_thr[1] = stk1.pop_back();
                    6'h0B: if (stk0.size() > 0) m_thr[0] = stk0.pop_back();
                    default: if (reg_addr[5]) m_prio[reg_addr[4:0]] = int'(reg_wdata[3:0]);
                endcase
            end
            for (int l = 0; l < 2; l++) begin
                ev[l] = nv[l]; ei[l] = ni[l]; ep[l] = np[l];
            end
        end
    end

    // compare lines and vectors on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 fast line", 32'(irq_fast_o), 32'(ev[1]));
            chk("R5 normal line", 32'(irq_norm_o), 32'(ev[0]));
            if (ev[1]) chk("R7 fast vector", 32'(vec_fast_o), 32'(ei[1]));
            if (ev[0]) chk("R7 normal vector", 32'(vec_norm_o), 32'(ei[0]));
        end
    end

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 chk(tag, reg_rdata, exp);
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic set_irq(input logic [31:0] v);
        @(negedge clk); irq = v;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 fast line low", 32'(irq_fast_o), 32'h0);
        chk("R1 normal line low", 32'(irq_norm_o), 32'h0);
        rd_chk(6'h00, 32'h0, "R1 enable");
        rd_chk(6'h01, 32'h0, "R1 route");
        rd_chk(6'h02, 32'h0, "R1 sw request");
        rd_chk(6'h0C, 32'h0, "R1 fast threshold");
        rd_chk(6'h0D, 32'h0, "R1 normal threshold");
        rd_chk(6'h08, 32'h0, "R1 fast vector");
        rd_chk(6'h09, 32'h0, "R1 normal vector");

        // R2 raw status, R6 priority zero stays silent
        set_irq(32'h8);
        wr_reg(6'h00, 32'h8);
        rd_chk(6'h04, 32'h8, "R2 raw shows hw level");
        rd_chk(6'h09, 32'h0, "R6 prio 0 gives no vector");

        // R5/R7 normal line, R8 ack, R9 eoi, R11 threshold read
        wr_reg(6'h23, 32'h5);
        rd_chk(6'h09, 32'h8000_0503, "R7 normal vector word");
        rd_chk(6'h0D, 32'h5, "R11 normal threshold after ack");
        wr_reg(6'h0B, 32'h0);
        rd_chk(6'h0D, 32'h0, "R9 normal threshold restored");

        // R5 routing to fast line
        wr_reg(6'h01, 32'h8);
        rd_chk(6'h08, 32'h8000_0503, "R5 routed to fast vector");
        wr_reg(6'h0A, 32'h0);

        // R7 tie goes to lowest index
        set_irq(32'h88);
        wr_reg(6'h27, 32'h5);
        wr_reg(6'h00, 32'h88);
        wr_reg(6'h01, 32'h88);
        rd_chk(6'h08, 32'h8000_0503, "R7 tie lowest index");
        wr_reg(6'h0A, 32'h0);

        // R7 higher priority wins, R8 threshold holds off lower
        wr_reg(6'h27, 32'h9);
        rd_chk(6'h08, 32'h8000_0907, "R7 highest priority wins");
        rd_chk(6'h0C, 32'h9, "R8 threshold set to winner");

        // R12-style disabled source: raw shows it, no vector, no push (R10)
        set_irq(32'h488);
        wr_reg(6'h2A, 32'hF);
        wr_reg(6'h01, 32'h488);
        rd_chk(6'h04, 32'h488, "R2 raw includes disabled source");
        rd_chk(6'h08, 32'h0, "R5 disabled source not served");
        rd_chk(6'h0C, 32'h9, "R10 invalid read does not push");

        // R8 nesting with higher priority
        wr_reg(6'h00, 32'h488);
        rd_chk(6'h08, 32'h8000_0F0A, "R8 nested higher source");
        rd_chk(6'h0C, 32'hF, "R8 nested threshold");
        wr_reg(6'h0A, 32'h0);
        rd_chk(6'h0C, 32'h9, "R9 pop to previous");
        wr_reg(6'h0A, 32'h0);
        wr_reg(6'h0A, 32'h0);
        rd_chk(6'h0C, 32'h0, "R9 eoi on empty ignored");

        // R4 level drop hands over to next source
        set_irq(32'h88);
        rd_chk(6'h08, 32'h8000_0907, "R4 dropped input leaves arbitration");
        wr_reg(6'h0A, 32'h0);

        // R3 software request set / clear
        set_irq(32'h0);
        wr_reg(6'h02, 32'h0010_0000);
        rd_chk(6'h02, 32'h0010_0000, "R3 sw set");
        rd_chk(6'h04, 32'h0010_0000, "R2 raw shows sw request");
        wr_reg(6'h03, 32'h0010_0000);
        rd_chk(6'h04, 32'h0, "R3 sw clear");
        set_irq(32'h8);
        wr_reg(6'h03, 32'h8);
        rd_chk(6'h04, 32'h8, "R3 hw level survives clear");

        // R5 both lines with separate vectors
        wr_reg(6'h25, 32'h2);
        wr_reg(6'h00, 32'h4A8);
        wr_reg(6'h02, 32'h20);
        rd_chk(6'h09, 32'h8000_0205, "R5 normal vector separate");
        rd_chk(6'h08, 32'h8000_0503, "R5 fast vector separate");
        wr_reg(6'h0B, 32'h0);
        wr_reg(6'h0A, 32'h0);

        // R10 stack depth
        set_irq(32'h0);
        wr_reg(6'h03, 32'hFFFF_FFFF);
        wr_reg(6'h01, 32'h01F0_0000);
        wr_reg(6'h00, 32'h01F0_0000);
        for (int k = 0; k < 5; k++) wr_reg(6'(6'h34 + k), 32'(k + 1));
        for (int k = 0; k < 5; k++) begin
            wr_reg(6'h02, 32'h1 << (20 + k));
            rd_chk(6'h08, 32'h8000_0000 | 32'((k + 1) << 8) | 32'(20 + k), "R10 fill stack vector");
            rd_chk(6'h0C, (k < 4) ? 32'(k + 1) : 32'h4, "R10 threshold while filling");
        end
        for (int k = 3; k >= 0; k--) begin
            wr_reg(6'h0A, 32'h0);
            rd_chk(6'h0C, 32'(k), "R9 unwind stack");
        end

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule